// File: doc/BRIEF.md
# Gate Program Validator

This block vets a stored list of fourteen gate instructions before a small logic evaluator is allowed to run it. Each slot holds a gate type, two operand codes and a destination code. An operand or destination names one of four external ports or one of ten scratch registers. The checker walks the slots from the first to the last and reads one slot per clock through a combinational slot-read port. It skips slots that are empty and tests every other slot against a fixed, ordered set of rules. The rules cover a missing gate type, the operand form a gate needs, operand clashes, registers read before anything writes them, and registers written more than once.

A one-cycle `start` pulse begins a scan. The scan ends at the first slot that breaks a rule, or after the last slot. At that point `done` rises, together with a pass/fail flag, an error code and the 1-based number of the offending slot. All of these hold until the next `start`. The block keeps its own record of which registers earlier slots have written.

Top module: `gpv_validator`

## Requirements
- R1: After reset, `rd_en`, `done` and `valid` are 0, and `err_code` and `err_slot` are 0.
- R2: A `start` pulse, also given while a scan is running, restarts the scan. In the cycle after `start`, `rd_en` is 1 and `rd_idx` is 0, and `rd_idx` then rises by one each clock. A scan that stops at slot N (1-based) raises `done` N clocks after `start`, with `rd_en` low.
- R3: Operand and destination codes are: 0 = empty, 1..4 = ports A..D, 5..14 = registers 0..9, and 15 = empty. A slot with gate code 0 and all three codes empty is skipped. A program of only empty slots is valid.
- R4: Gate codes are: 0 none, 1 AND, 2 OR, 3 NOT, 4 XOR, 5 NAND, 6 BUF, 7 XNOR. A non-empty slot with gate code 0 fails with error 1.
- R5: A NOT or BUF slot must have an empty first operand, a present second operand and a present destination. Otherwise it fails with error 2.
- R6: Any other gate needs both operands and the destination present. Otherwise it fails with error 3.
- R7: Two present operands with the same code fail with error 4, whether they name a port or a register.
- R8: A destination register equal to either operand register fails with error 5. A destination port equal to an operand port is allowed.
- R9: An operand register that no earlier slot wrote fails with error 6 for the first operand and error 7 for the second.
- R10: A destination register that an earlier slot already wrote fails with error 8.
- R11: Within a slot, the lowest-numbered failing rule is reported. The scan stops at the first failing slot, and `err_slot` gives its 1-based number (1..14).
- R12: On a clean program, `done` rises 14 clocks after `start` with `valid`=1, `err_code`=0 and `err_slot`=0. All results stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a scan |
| rd_en | output | 1 | Slot-read active; high while scanning |
| rd_idx | output | 4 | 0-based slot being read |
| rd_gate | input | 3 | Gate code of the addressed slot |
| rd_op1 | input | 4 | First operand code of the addressed slot |
| rd_op2 | input | 4 | Second operand code of the addressed slot |
| rd_dst | input | 4 | Destination code of the addressed slot |
| done | output | 1 | Scan finished; results valid |
| valid | output | 1 | Program passed every rule |
| err_code | output | 4 | 0 on pass, 1..8 for the first rule broken |
| err_slot | output | 4 | 1-based failing slot, 0 on pass |

## Verification
The main internal state is the written-register record. If it were wrong, an error code of 6, 7 or 8 would appear where none is due, or would be missing. This shows up at the ports in the clock where the scan reaches the first slot that reads or rewrites the affected register, which is at most 14 clocks after `start`. A wrong slot counter shows up at once on `rd_idx`, and as a wrong `done` time or `err_slot`. A wrong rule priority shows up as a different code on slots that break several rules at the same time.

// File: rtl/gpv_pkg.sv
package gpv_pkg;

    localparam int N_PORTS  = 4;
    localparam int N_REGS   = 10;
    localparam int OP_W     = $clog2(N_PORTS + N_REGS + 1);
    localparam int GATE_W   = 3;
    localparam int ERR_W    = 4;
    localparam int REG_LO   = N_PORTS + 1;
    localparam int REG_HI   = N_PORTS + N_REGS;

    typedef enum logic [GATE_W-1:0] {
        G_NONE = 3'd0,
        G_AND  = 3'd1,
        G_OR   = 3'd2,
        G_NOT  = 3'd3,
        G_XOR  = 3'd4,
        G_NAND = 3'd5,
        G_BUF  = 3'd6,
        G_XNOR = 3'd7
    } gate_e;

    // Order of the codes is the order in which rules are applied.
    typedef enum logic [ERR_W-1:0] {
        E_OK         = 4'd0,
        E_NO_GATE    = 4'd1,
        E_UNARY_FORM = 4'd2,
        E_BIN_FORM   = 4'd3,
        E_SAME_OPS   = 4'd4,
        E_DST_CLASH  = 4'd5,
        E_OP1_UNDEF  = 4'd6,
        E_OP2_UNDEF  = 4'd7,
        E_REDEF      = 4'd8
    } err_e;

    typedef enum logic {S_IDLE, S_SCAN} scan_st_e;

    typedef struct packed {
        logic [GATE_W-1:0] gate;
        logic [OP_W-1:0]   src1;
        logic [OP_W-1:0]   src2;
        logic [OP_W-1:0]   dst;
    } slot_t;

    // Codes beyond the register range carry no operand.
    function automatic logic op_absent(input logic [OP_W-1:0] code);
        return (code == '0) || (int'(code) > REG_HI);
    endfunction

    function automatic logic gate_unary(input logic [GATE_W-1:0] g);
        return (g == G_NOT) || (g == G_BUF);
    endfunction

endpackage

// File: rtl/gpv_slot_rules.sv
module gpv_slot_rules
    import gpv_pkg::*;
(
    input  slot_t             slot,
    input  logic [N_REGS-1:0] defined,
    output err_e              err,
    output logic [N_REGS-1:0] dst_hot
);

    logic [N_REGS-1:0] s1_hot;
    logic [N_REGS-1:0] s2_hot;
    logic              s1_none, s2_none, d_none, empty_slot, unary;

    generate
        for (genvar r = 0; r < N_REGS; r++) begin : g_hot
            assign s1_hot[r]  = (slot.src1 == OP_W'(REG_LO + r));
            assign s2_hot[r]  = (slot.src2 == OP_W'(REG_LO + r));
            assign dst_hot[r] = (slot.dst  == OP_W'(REG_LO + r));
        end
    endgenerate

    assign s1_none    = op_absent(slot.src1);
    assign s2_none    = op_absent(slot.src2);
    assign d_none     = op_absent(slot.dst);
    assign unary      = gate_unary(slot.gate);
    assign empty_slot = (slot.gate == G_NONE) && s1_none && s2_none && d_none;

    always_comb begin
        err = E_OK;
        if (empty_slot)
            err = E_OK;
        else if (slot.gate == G_NONE)
            err = E_NO_GATE;
        else if (unary && (!s1_none || s2_none || d_none))
            err = E_UNARY_FORM;
        else if (!unary && (s1_none || s2_none || d_none))
            err = E_BIN_FORM;
        else if (!s1_none && !s2_none && (slot.src1 == slot.src2))
            err = E_SAME_OPS;
        else if (|(dst_hot & (s1_hot | s2_hot)))
            err = E_DST_CLASH;
        else if ((|s1_hot) && !(|(s1_hot & defined)))
            err = E_OP1_UNDEF;
        else if ((|s2_hot) && !(|(s2_hot & defined)))
            err = E_OP2_UNDEF;
        else if (|(dst_hot & defined))
            err = E_REDEF;
    end

endmodule

// File: rtl/gpv_def_tracker.sv
module gpv_def_tracker
    import gpv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              upd,
    input  logic [N_REGS-1:0] set_mask,
    output logic [N_REGS-1:0] defined
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            defined <= '0;
        else if (upd)
            defined <= defined | set_mask;
    end

endmodule

// File: rtl/gpv_scan_ctrl.sv
module gpv_scan_ctrl
    import gpv_pkg::*;
#(
    parameter int N_SLOTS = 14,
    localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  err_e             slot_err,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             def_clear,
    output logic             def_upd,
    output logic             done,
    output logic             valid,
    output err_e             err_code,
    output logic [IDX_W-1:0] err_slot
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    scan_st_e st;

    assign rd_en     = (st == S_SCAN);
    assign def_clear = start;
    assign def_upd   = (st == S_SCAN) && !start && (slot_err == E_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            rd_idx   <= '0;
            done     <= 1'b0;
            valid    <= 1'b0;
            err_code <= E_OK;
            err_slot <= '0;
        end else if (start) begin
            st       <= S_SCAN;
            rd_idx   <= '0;
            done     <= 1'b0;
            valid    <= 1'b0;
            err_code <= E_OK;
            err_slot <= '0;
        end else if (st == S_SCAN) begin
            if (slot_err != E_OK) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                err_code <= slot_err;
                err_slot <= rd_idx + 1'b1;
            end else if (rd_idx == LAST) begin
                st    <= S_IDLE;
                done  <= 1'b1;
                valid <= 1'b1;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gpv_validator.sv
module gpv_validator
    import gpv_pkg::*;
#(
    parameter int N_SLOTS = 14,
    localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [GATE_W-1:0] rd_gate,
    input  logic [OP_W-1:0]   rd_op1,
    input  logic [OP_W-1:0]   rd_op2,
    input  logic [OP_W-1:0]   rd_dst,
    output logic              done,
    output logic              valid,
    output logic [ERR_W-1:0]  err_code,
    output logic [IDX_W-1:0]  err_slot
);

    slot_t             cur;
    err_e              slot_err;
    err_e              err_q;
    logic [N_REGS-1:0] wr_mask;
    logic [N_REGS-1:0] defined;
    logic              def_clear, def_upd;

    assign cur.gate = rd_gate;
    assign cur.src1 = rd_op1;
    assign cur.src2 = rd_op2;
    assign cur.dst  = rd_dst;

    gpv_slot_rules u_rules (
        .slot    (cur),
        .defined (defined),
        .err     (slot_err),
        .dst_hot (wr_mask)
    );

    gpv_def_tracker u_defs (
        .clk      (clk),
        .rst      (rst),
        .clear    (def_clear),
        .upd      (def_upd),
        .set_mask (wr_mask),
        .defined  (defined)
    );

    gpv_scan_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .slot_err  (slot_err),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .def_clear (def_clear),
        .def_upd   (def_upd),
        .done      (done),
        .valid     (valid),
        .err_code  (err_q),
        .err_slot  (err_slot)
    );

    assign err_code = err_q;

endmodule

// File: rtl/gpv_validator_chk.sv
module gpv_validator_chk #(
    parameter int N_SLOTS = 14,
    localparam int IDX_W  = $clog2(N_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             rd_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic             done,
    input logic             valid,
    input logic [3:0]       err_code,
    input logic [IDX_W-1:0] err_slot
);

    p_start_scan_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (rd_en && rd_idx == '0 && !done));

    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !start) |=> ((rd_en && rd_idx == $past(rd_idx) + 1'b1) || done));

    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(valid) && $stable(err_code) && $stable(err_slot)));

    p_pass_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (err_code == 4'd0 && err_slot == '0));

    p_fail_slot_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !valid) |-> (err_code != 4'd0 && err_code <= 4'd8
                              && err_slot != '0 && int'(err_slot) <= N_SLOTS));

endmodule

bind gpv_validator gpv_validator_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .done     (done),
    .valid    (valid),
    .err_code (err_code),
    .err_slot (err_slot)
);

// File: tb/sim_gpv_validator.sv
`timescale 1ns/1ps
module sim_gpv_validator;

    localparam int NS = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_en;
    logic [3:0] rd_idx;
    logic [2:0] rd_gate;
    logic [3:0] rd_op1, rd_op2, rd_dst;
    logic       done, valid;
    logic [3:0] err_code, err_slot;

    int pg [NS];
    int pa [NS];
    int pb [NS];
    int pd [NS];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always_comb begin
        if (int'(rd_idx) < NS) begin
            rd_gate = 3'(pg[int'(rd_idx)]);
            rd_op1  = 4'(pa[int'(rd_idx)]);
            rd_op2  = 4'(pb[int'(rd_idx)]);
            rd_dst  = 4'(pd[int'(rd_idx)]);
        end else begin
            rd_gate = '0; rd_op1 = '0; rd_op2 = '0; rd_dst = '0;
        end
    end

    gpv_validator u0 (
        .clk(clk), .rst(rst), .start(start),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_gate(rd_gate), .rd_op1(rd_op1), .rd_op2(rd_op2), .rd_dst(rd_dst),
        .done(done), .valid(valid), .err_code(err_code), .err_slot(err_slot)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < NS; i++) begin
            pg[i] = 0; pa[i] = 0; pb[i] = 0; pd[i] = 0;
        end
    endtask

    task automatic put(int i, int g, int a, int b, int d);
        pg[i] = g; pa[i] = a; pb[i] = b; pd[i] = d;
    endtask

    function automatic bit none(int c);
        return (c == 0) || (c > 14);
    endfunction

    function automatic bit isreg(int c);
        return (c >= 5) && (c <= 14);
    endfunction

    // Reference: expected code and 1-based slot (0 when clean).
    task automatic ref_eval(output int code, output int slot);
        bit wr [10];
        for (int r = 0; r < 10; r++) wr[r] = 0;
        code = 0;
        slot = 0;
        for (int s = 0; s < NS; s++) begin
            int g, a, b, d, e;
            bit un;
            g = pg[s]; a = pa[s]; b = pb[s]; d = pd[s];
            e = 0;
            un = (g == 3) || (g == 6);
            if (g == 0 && none(a) && none(b) && none(d)) continue;
            if (g == 0) e = 1;
            else if (un && (!none(a) || none(b) || none(d))) e = 2;
            else if (!un && (none(a) || none(b) || none(d))) e = 3;
            else if (!none(a) && !none(b) && a == b) e = 4;
            else if (isreg(d) && (d == a || d == b)) e = 5;
            else if (isreg(a) && !wr[a-5]) e = 6;
            else if (isreg(b) && !wr[b-5]) e = 7;
            else if (isreg(d) && wr[d-5]) e = 8;
            if (e != 0) begin
                code = e;
                slot = s + 1;
                return;
            end
            if (isreg(d)) wr[d-5] = 1;
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Start a scan and compare all outputs on every clock.
    // cut > 0: abandon after cut cycles (caller restarts).
    task automatic run(string req, int cut);
        int code, slot, lat, lim;
        ref_eval(code, slot);
        lat = (slot == 0) ? NS : slot;
        lim = (cut > 0) ? cut : lat + 3;
        pulse_start();
        for (int k = 0; k < lim; k++) begin
            chk("R2", "rd_en", int'(rd_en), int'(k < lat));
            chk(req, "done", int'(done), int'(k >= lat));
            if (k < lat) chk("R2", "rd_idx", int'(rd_idx), k);
            else begin
                chk(req, "valid", int'(valid), int'(code == 0));
                chk(req, "err_code", int'(err_code), code);
                chk(req, "err_slot", int'(err_slot), slot);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        clear_prog();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "rd_en", int'(rd_en), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "valid", int'(valid), 0);
        chk("R1", "err_code", int'(err_code), 0);
        chk("R1", "err_slot", int'(err_slot), 0);
        @(negedge clk);

        // R3 all empty program is clean; R12 latency 14
        clear_prog();
        run("R3", 0);
        chk("R12", "valid_all_empty", int'(valid), 1);

        // R8 port dest equal to operand port allowed; R12 full clean chain
        clear_prog();
        put(0, 1, 1, 2, 5);
        put(1, 3, 0, 5, 6);
        put(2, 4, 5, 6, 3);
        put(3, 6, 0, 1, 1);
        put(5, 5, 6, 4, 7);
        put(13, 7, 7, 5, 4);
        run("R12", 0);
        chk("R8", "port_reuse_valid", int'(valid), 1);

        // R4 missing gate after an empty slot
        clear_prog();
        put(1, 0, 1, 0, 0);
        run("R4", 0);
        chk("R4", "code", int'(err_code), 1);

        // R5 NOT with first operand present
        clear_prog();
        put(0, 3, 1, 2, 3);
        run("R5", 0);

        // R5 BUF with no destination
        clear_prog();
        put(0, 6, 0, 2, 0);
        run("R5", 0);

        // R6 AND without destination
        clear_prog();
        put(0, 1, 1, 2, 0);
        run("R6", 0);

        // R7 identical port operands
        clear_prog();
        put(0, 2, 2, 2, 3);
        run("R7", 0);

        // R8 dest register equals operand register; beats R10
        clear_prog();
        put(0, 1, 1, 2, 5);
        put(1, 2, 5, 1, 5);
        run("R8", 0);
        chk("R11", "priority_5_over_8", int'(err_code), 5);

        // R9 first operand register undefined
        clear_prog();
        put(0, 1, 8, 1, 2);
        run("R9", 0);

        // R9 second operand undefined; R11 both undefined -> 6
        clear_prog();
        put(0, 1, 1, 7, 2);
        run("R9", 0);
        clear_prog();
        put(0, 4, 9, 10, 2);
        run("R11", 0);
        chk("R11", "priority_6_over_7", int'(err_code), 6);

        // R9 register defined only later
        clear_prog();
        put(0, 6, 0, 10, 1);
        put(1, 6, 0, 1, 10);
        run("R9", 0);

        // R10 register written twice
        clear_prog();
        put(0, 1, 1, 2, 9);
        put(1, 4, 3, 4, 9);
        run("R10", 0);

        // R11 failure in the last slot
        clear_prog();
        put(0, 1, 1, 2, 5);
        put(13, 1, 5, 6, 1);
        run("R11", 0);
        chk("R11", "last_slot", int'(err_slot), 14);

        // R3 code 15 counts as empty
        clear_prog();
        put(0, 0, 15, 15, 15);
        put(1, 5, 1, 2, 3);
        run("R3", 0);

        // R2 restart mid-scan with a new program
        clear_prog();
        put(0, 1, 1, 2, 9);
        put(1, 4, 3, 4, 9);
        put(4, 1, 1, 1, 2);
        run("R2", 1);
        clear_prog();
        put(0, 1, 1, 2, 5);
        put(1, 2, 5, 3, 4);
        run("R2", 0);
        chk("R2", "restart_valid", int'(valid), 1);

        summary();
    end

endmodule